// File: doc/BRIEF.md
# Index Register Execution Unit

This block holds the index register of an 18-bit accumulator machine whose memory-reference words have a 13-bit address field. It forms the effective address for indexed instructions. It also executes the instructions that read or write the index register: indexed stores, the store of the low index bits, add-one to memory, loading the index register and adding to it, subroutine linkage, and the loop-control transfer that moves the index toward zero. In addition it computes the next program counter for every transfer-class instruction.

The index register is an 18-bit one's-complement value. Both the effective-address sum and the full-word sums use end-around carry, in their own width. The surrounding machine supplies three things:

- the instruction split into a 2-bit class and a 3-bit sub-opcode,
- the address field, together with the memory word read at the effective address in the same cycle,
- the accumulator and the address of the current instruction.

Each cycle in which `exec` is high retires one instruction. The memory, accumulator and MBR write strobes and the next PC are combinational outputs for that cycle. The index register updates on the clock edge that ends it.

Top module: `xr_unit`

## Requirements
- R1: When reset (`rst_n` low, asynchronous) is active, `xr` is 0. It is still 0 in the first cycle after reset is released.
- R2: `ea` equals `addr + xr[12:0]` with 13-bit end-around carry for these (class, sub-opcode) pairs: (0,1), (0,5), (1,1), (1,5), (1,7), (2,5). For every other pair `ea` equals `addr`.
- R3: While `exec` is high, store-indexed (0,1) raises `mem_we` with `mem_wdata = ac`. Store-index (0,2) raises `mem_we` with `mem_wdata` set to `xr[12:0]`, zero-extended. No other instruction except the one in R4 raises `mem_we`.
- R4: While `exec` is high, add-one (0,3) raises both `mem_we` and `ac_we`. It drives `mem_wdata` and `ac_wdata` with `mem_rdata + 1`, using 18-bit end-around carry.
- R5: Load-index (1,2) sets `xr` to `mem_rdata` at the clock edge. Add-to-index (1,3) sets `xr` to `xr + mem_rdata` with 18-bit end-around carry.
- R6: Transfer-and-link (2,2) sets `next_pc = addr`. At the clock edge it sets `xr` to `pc + 1` (modulo 2^13), zero-extended.
- R7: Loop-transfer (2,3) with `xr` negative and not all ones adds 1 to `xr`. With `xr` positive and nonzero it subtracts 1 from `xr`. In both cases `next_pc = addr`.
- R8: Loop-transfer with `xr` equal to 0 or to all ones leaves `xr` unchanged and gives `next_pc = pc + 1`.
- R9: These transfers go to `addr` when their condition holds and otherwise give `pc + 1`:
  - (2,0) when `ac[17]` is 1,
  - (2,1) when `ac` is 0 or all ones,
  - (2,4) always,
  - (2,6) when `level_low` is 1.
  Indexed transfer (2,5) always goes to `ea`.
- R10: `next_pc` is `pc + 1` (modulo 2^13) in these cases: `exec` is low, the class is not 2, or the pair is (2,7).
- R11: In class 3 with `exec` high, `xmb_req` raises `mbr_we` with `mbr_wdata` equal to the current `xr`. In the same case `mbx_req` loads `mbr_in` into `xr` at the clock edge. In any other class both requests are ignored.
- R12: `xr` holds its value whenever `exec` is low, and for every instruction not named in R5, R6, R7 or R11. While `exec` is low, `mem_we`, `ac_we` and `mbr_we` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Execute the presented instruction this cycle |
| op_class | input | 2 | Instruction class |
| sub_op | input | 3 | Sub-opcode within the class |
| addr | input | 13 | Address field |
| mem_rdata | input | 18 | Memory word at `ea` this cycle |
| ac | input | 18 | Accumulator |
| pc | input | 13 | Address of the current instruction |
| mbr_in | input | 18 | Memory buffer register contents |
| xmb_req | input | 1 | Operate-class request: copy index to MBR |
| mbx_req | input | 1 | Operate-class request: copy MBR to index |
| level_low | input | 1 | External level input, high when the level is at 0 V |
| ea | output | 13 | Effective address |
| next_pc | output | 13 | Next program counter |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 18 | Memory write data |
| ac_we | output | 1 | Accumulator write strobe |
| ac_wdata | output | 18 | Accumulator write data |
| mbr_we | output | 1 | MBR write strobe |
| mbr_wdata | output | 18 | MBR write data |
| xr | output | 18 | Index register |

## Verification
The assertions assume that `mem_rdata` is the word at the `ea` of the same cycle. They also assume that `pc` is the address of the executing instruction, so the link value and the fall-through address are both `pc + 1`. The bench holds all inputs steady from the falling edge through the next rising edge. It draws `mem_rdata` often from the values 0, all ones, ±1 and ±2, so that the loop transfer reaches both zero encodings from both signs. Directed sequences load each zero form and step a small index of each sign down to zero.

// File: rtl/xr_pkg.sv
package xr_pkg;

    parameter int XR_WORD_W = 18;
    parameter int XR_ADDR_W = 13;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_STX,
        OP_SXA,
        OP_ADO,
        OP_LDX,
        OP_AUX,
        OP_TRN,
        OP_TZE,
        OP_TSX,
        OP_TIX,
        OP_TRA,
        OP_TRX,
        OP_TLV,
        OP_OPR
    } xr_op_e;

    typedef struct packed {
        logic [XR_WORD_W-1:0] xr;
    } xr_state_t;

endpackage

// File: rtl/oc_adder.sv
module oc_adder #(
    parameter int W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] raw;

    // The end-around carry is folded back into the low bit.
    // It cannot ripple out a second time.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/xr_decode.sv
module xr_decode
    import xr_pkg::*;
(
    input  logic [1:0] op_class,
    input  logic [2:0] sub_op,
    output xr_op_e     op,
    output logic       indexed
);
    always_comb begin
        op      = OP_NONE;
        indexed = 1'b0;
        case ({op_class, sub_op})
            5'b00_001: begin op = OP_STX; indexed = 1'b1; end
            5'b00_010: op = OP_SXA;
            5'b00_011: op = OP_ADO;
            5'b00_101: indexed = 1'b1;
            5'b01_001: indexed = 1'b1;
            5'b01_010: op = OP_LDX;
            5'b01_011: op = OP_AUX;
            5'b01_101: indexed = 1'b1;
            5'b01_111: indexed = 1'b1;
            5'b10_000: op = OP_TRN;
            5'b10_001: op = OP_TZE;
            5'b10_010: op = OP_TSX;
            5'b10_011: op = OP_TIX;
            5'b10_100: op = OP_TRA;
            5'b10_101: begin op = OP_TRX; indexed = 1'b1; end
            5'b10_110: op = OP_TLV;
            default: begin
                if (op_class == 2'b11) op = OP_OPR;
            end
        endcase
    end
endmodule

// File: rtl/xr_branch.sv
module xr_branch
    import xr_pkg::*;
(
    input  xr_op_e               op,
    input  logic                 exec,
    input  logic [XR_WORD_W-1:0] ac,
    input  logic [XR_WORD_W-1:0] xr,
    input  logic                 level_low,
    input  logic [XR_ADDR_W-1:0] addr,
    input  logic [XR_ADDR_W-1:0] ea,
    input  logic [XR_ADDR_W-1:0] pc_inc,
    output logic [XR_ADDR_W-1:0] next_pc
);
    logic ac_zero;
    logic xr_zero;
    logic take;

    always_comb begin
        ac_zero = (ac == '0) || (&ac);
        xr_zero = (xr == '0) || (&xr);
        take    = 1'b0;
        case (op)
            OP_TRN:  take = ac[XR_WORD_W-1];
            OP_TZE:  take = ac_zero;
            OP_TSX:  take = 1'b1;
            OP_TIX:  take = !xr_zero;
            OP_TRA:  take = 1'b1;
            OP_TLV:  take = level_low;
            default: take = 1'b0;
        endcase
        if (!exec)
            next_pc = pc_inc;
        else if (op == OP_TRX)
            next_pc = ea;
        else if (take)
            next_pc = addr;
        else
            next_pc = pc_inc;
    end
endmodule

// File: rtl/xr_unit.sv
module xr_unit
    import xr_pkg::*;
#(
    parameter int WORD_W = XR_WORD_W,
    parameter int ADDR_W = XR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [1:0]        op_class,
    input  logic [2:0]        sub_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] ac,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] mbr_in,
    input  logic              xmb_req,
    input  logic              mbx_req,
    input  logic              level_low,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] next_pc,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              ac_we,
    output logic [WORD_W-1:0] ac_wdata,
    output logic              mbr_we,
    output logic [WORD_W-1:0] mbr_wdata,
    output logic [WORD_W-1:0] xr
);
    localparam int PAD_W = WORD_W - ADDR_W;

    xr_state_t         st_q;
    xr_state_t         st_d;
    xr_op_e            op;
    logic              indexed;
    logic [ADDR_W-1:0] ea_sum;
    logic [ADDR_W-1:0] pc_inc;
    logic [WORD_W-1:0] inc_sum;
    logic [WORD_W-1:0] aux_sum;
    logic              tix_neg;
    logic              tix_pos;

    xr_decode u_dec (
        .op_class (op_class),
        .sub_op   (sub_op),
        .op       (op),
        .indexed  (indexed)
    );

    oc_adder #(.W(ADDR_W)) u_ea_add (
        .a   (addr),
        .b   (st_q.xr[ADDR_W-1:0]),
        .sum (ea_sum)
    );

    oc_adder #(.W(WORD_W)) u_inc_add (
        .a   (mem_rdata),
        .b   (WORD_W'(1)),
        .sum (inc_sum)
    );

    oc_adder #(.W(WORD_W)) u_aux_add (
        .a   (st_q.xr),
        .b   (mem_rdata),
        .sum (aux_sum)
    );

    assign ea     = indexed ? ea_sum : addr;
    assign pc_inc = pc + 1'b1;
    assign xr     = st_q.xr;

    xr_branch u_br (
        .op        (op),
        .exec      (exec),
        .ac        (ac),
        .xr        (st_q.xr),
        .level_low (level_low),
        .addr      (addr),
        .ea        (ea),
        .pc_inc    (pc_inc),
        .next_pc   (next_pc)
    );

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_wdata = ac;
        ac_we     = 1'b0;
        ac_wdata  = inc_sum;
        mbr_we    = 1'b0;
        mbr_wdata = st_q.xr;
        tix_neg   = st_q.xr[WORD_W-1] && !(&st_q.xr);
        tix_pos   = !st_q.xr[WORD_W-1] && (st_q.xr != '0);
        if (exec) begin
            case (op)
                OP_STX: mem_we = 1'b1;
                OP_SXA: begin
                    mem_we    = 1'b1;
                    mem_wdata = {{PAD_W{1'b0}}, st_q.xr[ADDR_W-1:0]};
                end
                OP_ADO: begin
                    mem_we    = 1'b1;
                    mem_wdata = inc_sum;
                    ac_we     = 1'b1;
                end
                OP_LDX: st_d.xr = mem_rdata;
                OP_AUX: st_d.xr = aux_sum;
                OP_TSX: st_d.xr = {{PAD_W{1'b0}}, pc_inc};
                OP_TIX: begin
                    if (tix_neg)
                        st_d.xr = st_q.xr + 1'b1;
                    else if (tix_pos)
                        st_d.xr = st_q.xr - 1'b1;
                end
                OP_OPR: begin
                    mbr_we = xmb_req;
                    if (mbx_req) st_d.xr = mbr_in;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R1
    xr_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (xr == '0));

    // R5
    ldx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_LDX) |=> (xr == $past(mem_rdata)));

    // R6
    tsx_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_TSX) |=> (xr == {{PAD_W{1'b0}}, $past(pc) + 1'b1}));

    // R7
    tix_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_TIX && !xr[WORD_W-1] && xr != '0)
        |=> (xr == $past(xr) - 1'b1));

    // R8
    tix_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_TIX && (xr == '0 || (&xr)))
        |-> (next_pc == pc_inc) ##1 $stable(xr));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(xr));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |-> !(mem_we || ac_we || mbr_we));

    // R3
    mem_we_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (op_class == 2'b00));
endmodule

// File: tb/xr_unit_tb.sv
module xr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec = 1'b0;
    logic [1:0]  op_class = '0;
    logic [2:0]  sub_op = '0;
    logic [12:0] addr = '0;
    logic [17:0] mem_rdata = '0;
    logic [17:0] ac = '0;
    logic [12:0] pc = '0;
    logic [17:0] mbr_in = '0;
    logic        xmb_req = 1'b0;
    logic        mbx_req = 1'b0;
    logic        level_low = 1'b0;
    logic [12:0] ea;
    logic [12:0] next_pc;
    logic        mem_we;
    logic [17:0] mem_wdata;
    logic        ac_we;
    logic [17:0] ac_wdata;
    logic        mbr_we;
    logic [17:0] mbr_wdata;
    logic [17:0] xr;

    int checks = 0;
    int failures = 0;
    logic [17:0] m_xr = '0;
    logic [17:0] m_xr_next = '0;
    string xr_tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    xr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exec(exec), .op_class(op_class),
        .sub_op(sub_op), .addr(addr), .mem_rdata(mem_rdata), .ac(ac),
        .pc(pc), .mbr_in(mbr_in), .xmb_req(xmb_req), .mbx_req(mbx_req),
        .level_low(level_low), .ea(ea), .next_pc(next_pc), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .ac_we(ac_we), .ac_wdata(ac_wdata),
        .mbr_we(mbr_we), .mbr_wdata(mbr_wdata), .xr(xr)
    );

    function automatic logic [17:0] oc18(input logic [17:0] a, input logic [17:0] b);
        logic [18:0] r;
        r = {1'b0, a} + {1'b0, b};
        return r[17:0] + {17'b0, r[18]};
    endfunction

    function automatic logic [12:0] oc13(input logic [12:0] a, input logic [12:0] b);
        logic [13:0] r;
        r = {1'b0, a} + {1'b0, b};
        return r[12:0] + {12'b0, r[13]};
    endfunction

    function automatic bit is_idx(input logic [1:0] c, input logic [2:0] s);
        case ({c, s})
            5'b00_001, 5'b00_101, 5'b01_001, 5'b01_101, 5'b01_111, 5'b10_101: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_xr();
        chk(xr_tag, "xr", 32'(xr), 32'(m_xr_next));
        m_xr = m_xr_next;
    endtask

    task automatic run_op(input bit e, input logic [1:0] c, input logic [2:0] s,
                          input logic [12:0] a, input logic [17:0] md, input logic [17:0] acv,
                          input logic [12:0] p, input logic [17:0] mb, input bit xm, input bit mx,
                          input bit lv);
        logic [12:0] e_ea, e_pc, pinc;
        bit e_mwe, e_awe, e_bwe, tk, nz;
        logic [17:0] e_mwd, e_nx;
        string pc_tag;
        @(negedge clk);
        check_xr();
        exec = e; op_class = c; sub_op = s; addr = a; mem_rdata = md; ac = acv;
        pc = p; mbr_in = mb; xmb_req = xm; mbx_req = mx; level_low = lv;
        #1;
        pinc = p + 13'd1;
        e_ea = is_idx(c, s) ? oc13(a, m_xr[12:0]) : a;
        e_mwe = 0; e_awe = 0; e_bwe = 0; e_mwd = '0; e_nx = m_xr; tk = 0;
        nz = (m_xr != 18'h0) && (m_xr != 18'h3FFFF);
        xr_tag = "R12"; pc_tag = "R10";
        e_pc = pinc;
        if (e) begin
            case ({c, s})
                5'b00_001: begin e_mwe = 1; e_mwd = acv; end
                5'b00_010: begin e_mwe = 1; e_mwd = {5'b0, m_xr[12:0]}; end
                5'b00_011: begin e_mwe = 1; e_awe = 1; e_mwd = oc18(md, 18'd1); end
                5'b01_010: begin e_nx = md; xr_tag = "R5"; end
                5'b01_011: begin e_nx = oc18(m_xr, md); xr_tag = "R5"; end
                5'b10_000: begin tk = acv[17]; pc_tag = "R9"; end
                5'b10_001: begin tk = (acv == 0) || (acv == 18'h3FFFF); pc_tag = "R9"; end
                5'b10_010: begin tk = 1; e_nx = {5'b0, pinc}; xr_tag = "R6"; pc_tag = "R6"; end
                5'b10_011: begin
                    tk = nz;
                    if (nz) begin
                        e_nx = m_xr[17] ? m_xr + 18'd1 : m_xr - 18'd1;
                        xr_tag = "R7"; pc_tag = "R7";
                    end else begin
                        xr_tag = "R8"; pc_tag = "R8";
                    end
                end
                5'b10_100: begin tk = 1; pc_tag = "R9"; end
                5'b10_110: begin tk = lv; pc_tag = "R9"; end
                default: ;
            endcase
            if (c == 2'b11) begin
                e_bwe = xm;
                if (mx) e_nx = mb;
                xr_tag = "R11";
            end
            if (tk) e_pc = a;
            if ({c, s} == 5'b10_101) begin e_pc = e_ea; pc_tag = "R9"; end
        end
        chk("R2", "ea", 32'(ea), 32'(e_ea));
        chk(pc_tag, "next_pc", 32'(next_pc), 32'(e_pc));
        chk((c == 0 && s == 3) ? "R4" : (e ? "R3" : "R12"), "mem_we", 32'(mem_we), 32'(e_mwe));
        if (e_mwe) chk((s == 3) ? "R4" : "R3", "mem_wdata", 32'(mem_wdata), 32'(e_mwd));
        chk(e ? "R4" : "R12", "ac_we", 32'(ac_we), 32'(e_awe));
        if (e_awe) chk("R4", "ac_wdata", 32'(ac_wdata), 32'(e_mwd));
        chk(e ? "R11" : "R12", "mbr_we", 32'(mbr_we), 32'(e_bwe));
        if (e_bwe) chk("R11", "mbr_wdata", 32'(mbr_wdata), 32'(m_xr));
        m_xr_next = e_nx;
    endtask

    function automatic logic [17:0] pick_word();
        case ($urandom % 8)
            0: return 18'h0;
            1: return 18'h3FFFF;
            2: return 18'd1;
            3: return 18'h3FFFE;
            4: return 18'd2;
            5: return 18'h3FFFD;
            default: return 18'($urandom);
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "xr in reset", 32'(xr), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "xr after release", 32'(xr), 32'd0);
        // R8: plus zero, then minus zero, do not move or branch
        run_op(1, 2'b10, 3'b011, 13'h0100, 0, 0, 13'h0010, 0, 0, 0, 0);
        run_op(1, 2'b01, 3'b010, 13'h0001, 18'h3FFFF, 0, 13'h0011, 0, 0, 0, 0);
        run_op(1, 2'b10, 3'b011, 13'h0100, 0, 0, 13'h0012, 0, 0, 0, 0);
        // R7: +2 steps down to plus zero; -2 steps up to minus zero
        run_op(1, 2'b01, 3'b010, 13'h0001, 18'd2, 0, 13'h0013, 0, 0, 0, 0);
        repeat (3) run_op(1, 2'b10, 3'b011, 13'h0200, 0, 0, 13'h0014, 0, 0, 0, 0);
        run_op(1, 2'b01, 3'b010, 13'h0001, 18'h3FFFD, 0, 13'h0015, 0, 0, 0, 0);
        repeat (3) run_op(1, 2'b10, 3'b011, 13'h0300, 0, 0, 13'h0016, 0, 0, 0, 0);
        // R2: end-around carry on effective address
        run_op(1, 2'b01, 3'b010, 13'h0001, 18'h01FFF, 0, 13'h0017, 0, 0, 0, 0);
        run_op(1, 2'b00, 3'b001, 13'h0005, 0, 18'h12345, 13'h0018, 0, 0, 0, 0);
        run_op(1, 2'b10, 3'b101, 13'h1FFF, 0, 0, 13'h0019, 0, 0, 0, 0);
        // R4: add-one to minus zero gives plus one
        run_op(1, 2'b00, 3'b011, 13'h0040, 18'h3FFFF, 0, 13'h001A, 0, 0, 0, 0);
        // R6: link at the top of memory wraps to zero
        run_op(1, 2'b10, 3'b010, 13'h0777, 0, 0, 13'h1FFF, 0, 0, 0, 0);
        // R11: requests outside class 3 are ignored
        run_op(1, 2'b01, 3'b100, 13'h0002, 0, 0, 13'h0020, 18'h2AAAA, 1, 1, 0);
        run_op(1, 2'b11, 3'b000, 13'h0002, 0, 0, 13'h0021, 18'h15555, 1, 1, 0);
        // R12: idle cycle
        run_op(0, 2'b01, 3'b010, 13'h0002, 18'h00077, 0, 13'h0022, 18'h1, 1, 1, 1);
        for (int i = 0; i < 3000; i++) begin
            run_op(($urandom % 8) != 0, 2'($urandom), 3'($urandom), 13'($urandom),
                   pick_word(), pick_word(), 13'($urandom), pick_word(),
                   1'($urandom), 1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        check_xr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule